// File: doc/BRIEF.md
# MMC Command Token Serializer

The block turns one card command into the 48-bit token that a host places on the single-wire command line of a MultiMediaCard, most significant bit first. A request supplies a 6-bit command index and a 32-bit argument. The block then shifts out the token one bit for each clock enable. The token holds a start bit, a host-direction bit, the index, the argument, a 7-bit CRC and an end bit.

The CRC is not held in a table. A 7-bit register folds in each header bit as it leaves the shift register. Once the 40 header bits are out, the same register shifts its contents onto the line. One token costs 40 header flops, 7 CRC flops and a 6-bit position counter, whatever the index or argument.

While a token is in flight the block raises a busy flag and an output-enable that marks when the line is driven. When the token is complete it gives a one-cycle done pulse. The bit-rate clock, open-drain handling and response capture belong to the surrounding logic.

Top module: `mmc_cmd_serializer`

## Requirements
- R1: While rst_ni is low and after it rises, busy_o is 0, done_o is 0, cmd_oe_o is 0 and cmd_o is 1.
- R2: In any clock cycle where req_i is 1 and busy_o is 0, the block latches idx_i and arg_i and sets busy_o on the next edge. From that edge cmd_o shows the start bit, which is 0.
- R3: Token bits 0 to 39 are, in this order: the start bit 0, the direction bit 1, the 6 index bits MSB first, and the 32 argument bits MSB first.
- R4: Token bits 40 to 46 carry the CRC7 MSB first. The CRC uses generator x^7+x^3+1, starts from zero and covers token bits 0 to 39.
- R5: Token bit 47 is the end bit, which is 1. busy_o stays high for exactly 48 enabled bit periods.
- R6: The token advances by one bit only on a clock edge with bit_en_i high. When bit_en_i is low, cmd_o and busy_o hold their values.
- R7: A request made while busy_o is 1 is ignored. The token in flight keeps its index, argument and timing.
- R8: done_o is 1 for exactly one cycle: the cycle after the edge that consumes the end bit. In that cycle busy_o is already 0.
- R9: cmd_oe_o equals busy_o at all times. cmd_o is 1 whenever busy_o is 0.
- R10: The final byte of a token (the CRC7 shifted left by one, with the end bit as bit 0) matches these values: 0x95 for index 0 with argument 0; 0x4D for index 2 with argument 0; 0x7F for index 3 with argument 0x00010000; 0xDD for index 7 with argument 0x00010000; 0x77 for index 11 with argument 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-rate enable; one token bit per enabled edge |
| req_i | input | 1 | Start a token (taken only when idle) |
| idx_i | input | 6 | Command index |
| arg_i | input | 32 | Command argument |
| busy_o | output | 1 | Token in flight |
| done_o | output | 1 | One-cycle pulse after the end bit |
| cmd_o | output | 1 | Serial command bit, 1 when idle |
| cmd_oe_o | output | 1 | Line drive enable |

## Verification
Five boot-sequence commands with fixed arguments are sent with the enable held high. Their final bytes are compared against known constants, which sets the CRC polynomial, seed and bit order apart from any self-consistent but wrong variant. The initialisation command with argument 0x80FF8000 and a run of random indices and arguments exercise every header bit position and the CRC over dense data. Sparse random enables show whether the block advances on the clock instead of the enable. A request injected mid-token must leave the frame unchanged, which catches a reload while busy.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned ARG_W   = 32;
  localparam int unsigned CRC_W   = 7;
  localparam int unsigned HDR_W   = 2 + IDX_W + ARG_W;
  localparam int unsigned FRAME_W = HDR_W + CRC_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;  // x^7 + x^3 + 1

  typedef enum logic [1:0] {
    PH_HDR,
    PH_CRC,
    PH_END
  } phase_e;
endpackage

// File: rtl/mmc_bit_seq.sv
module mmc_bit_seq
  import mmc_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             req_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             adv_o,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CRC_POS  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] END_POS  = CNT_W'(HDR_W + CRC_W);

  logic             busy_q, done_q, last;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = req_i & ~busy_q;
  assign adv_o  = busy_q & bit_en_i;
  assign last   = adv_o & (cnt_q == LAST_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (adv_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (cnt_q < CRC_POS)      phase_o = PH_HDR;
    else if (cnt_q < END_POS) phase_o = PH_CRC;
    else                      phase_o = PH_END;
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign cnt_o  = cnt_q;

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q && !busy_q);
  assert_no_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && req_i && !last |=>
      busy_q && cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, $past(bit_en_i)});
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !bit_en_i |=> busy_q && $stable(cnt_q));
endmodule

// File: rtl/mmc_crc7.sv
module mmc_crc7
  import mmc_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic shift_i,
  input  logic din_i,
  output logic msb_o
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb = crc_q[CRC_W-1] ^ din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (step_i)  crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    else if (shift_i) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign msb_o = crc_q[CRC_W-1];

  assert_clear_seed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == '0);
  assert_shift_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !clr_i && !step_i |=> crc_q == {$past(crc_q[CRC_W-2:0]), 1'b0});
endmodule

// File: rtl/mmc_cmd_serializer.sv
module mmc_cmd_serializer
  import mmc_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             req_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             cmd_o,
  output logic             cmd_oe_o
);
  logic             load, adv, crc_msb, line_bit;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] hdr_q;

  mmc_bit_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .req_i    (req_i),
    .load_o   (load),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .adv_o    (adv),
    .phase_o  (phase),
    .cnt_o    (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hdr_q <= '0;
    else if (load)                   hdr_q <= {1'b0, 1'b1, idx_i, arg_i};
    else if (adv && phase == PH_HDR) hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
  end

  mmc_crc7 u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load),
    .step_i  (adv && phase == PH_HDR),
    .shift_i (adv && phase == PH_CRC),
    .din_i   (hdr_q[HDR_W-1]),
    .msb_o   (crc_msb)
  );

  always_comb begin
    unique case (phase)
      PH_HDR:  line_bit = hdr_q[HDR_W-1];
      PH_CRC:  line_bit = crc_msb;
      default: line_bit = 1'b1;
    endcase
  end

  assign cmd_o    = busy_o ? line_bit : 1'b1;
  assign cmd_oe_o = busy_o;

  assert_idle_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cmd_o && !cmd_oe_o);
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !cmd_o);
  assert_end_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt == CNT_W'(FRAME_W - 1) |-> cmd_o);
  assert_line_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !bit_en_i |=> $stable(cmd_o));
endmodule

// File: tb/mmc_cmd_serializer_tb.sv
module mmc_cmd_serializer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        req_i = 1'b0;
  logic [5:0]  idx_i = '0;
  logic [31:0] arg_i = '0;
  logic        busy_o, done_o, cmd_o, cmd_oe_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4ns clk_i = ~clk_i;

  mmc_cmd_serializer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .req_i(req_i),
    .idx_i(idx_i), .arg_i(arg_i), .busy_o(busy_o), .done_o(done_o),
    .cmd_o(cmd_o), .cmd_oe_o(cmd_oe_o)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] hdr);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = c[6] ^ hdr[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] hdr = {2'b01, idx, arg};
    return {hdr, ref_crc(hdr), 1'b1};
  endfunction

  // dense: enable every cycle; inject: request mid-token
  task automatic run_frame(input logic [5:0] idx, input logic [31:0] arg,
                           input bit dense, input bit inject, output logic [47:0] got);
    int  n = 0;
    logic last_val;
    bit  last_en = 1'b1;
    @(negedge clk_i);
    idx_i = idx; arg_i = arg; req_i = 1'b1; bit_en_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o, 1, "R2 busy after request");
    chk(cmd_o, 0, "R2 start bit on line");
    idx_i = $urandom; arg_i = $urandom;
    got = '0;
    while (n < 48) begin
      if (!last_en) chk(cmd_o, last_val, "R6 line held without enable");
      chk(busy_o, 1, "R5 busy within token");
      chk(cmd_oe_o, busy_o, "R9 oe follows busy");
      bit_en_i = dense ? 1'b1 : (($urandom % 3) == 0);
      req_i = inject && (n == 20);
      if (bit_en_i) begin
        got[47-n] = cmd_o;
        n++;
      end
      last_en = bit_en_i;
      last_val = cmd_o;
      @(negedge clk_i);
    end
    req_i = 1'b0;
    bit_en_i = 1'b0;
    chk(busy_o, 0, "R5 busy low after 48 bits");
    chk(done_o, 1, "R8 done pulse");
    chk(cmd_o, 1, "R9 idle line high");
    chk(cmd_oe_o, 0, "R9 oe low when idle");
    @(negedge clk_i);
    chk(done_o, 0, "R8 done one cycle");
  endtask

  task automatic check_frame(input logic [5:0] idx, input logic [31:0] arg,
                             input logic [47:0] got, input string tag);
    logic [47:0] exp = ref_frame(idx, arg);
    chk(got[47:8], exp[47:8], {tag, " R3 header"});
    chk(got[7:1], exp[7:1], {tag, " R4 crc7"});
    chk(got[0], 1, {tag, " R5 end bit"});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] got;
    logic [5:0]  ri;
    logic [31:0] ra;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk({busy_o, done_o, cmd_oe_o, cmd_o}, 4'b0001, "R1 state in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk({busy_o, done_o, cmd_oe_o, cmd_o}, 4'b0001, "R1 state after reset");

    // R10 known tails, enable every cycle
    run_frame(6'd0, 32'h0, 1, 0, got);
    chk(got[7:0], 8'h95, "R10 idx0 tail");  check_frame(6'd0, 32'h0, got, "idx0");
    run_frame(6'd2, 32'h0, 1, 0, got);
    chk(got[7:0], 8'h4D, "R10 idx2 tail");  check_frame(6'd2, 32'h0, got, "idx2");
    run_frame(6'd3, 32'h00010000, 1, 0, got);
    chk(got[7:0], 8'h7F, "R10 idx3 tail");  check_frame(6'd3, 32'h00010000, got, "idx3");
    run_frame(6'd7, 32'h00010000, 1, 0, got);
    chk(got[7:0], 8'hDD, "R10 idx7 tail");  check_frame(6'd7, 32'h00010000, got, "idx7");
    run_frame(6'd11, 32'h0, 1, 0, got);
    chk(got[7:0], 8'h77, "R10 idx11 tail"); check_frame(6'd11, 32'h0, got, "idx11");
    run_frame(6'd1, 32'h80FF8000, 0, 0, got);
    check_frame(6'd1, 32'h80FF8000, got, "idx1 sparse");
    // R7 request mid-token ignored
    run_frame(6'd2, 32'h0, 0, 1, got);
    chk(got, ref_frame(6'd2, 32'h0), "R7 inject idx2");
    run_frame(6'h3F, 32'hFFFFFFFF, 1, 1, got);
    chk(got, ref_frame(6'h3F, 32'hFFFFFFFF), "R7 inject all ones");

    for (int k = 0; k < 40; k++) begin
      ri = $urandom;
      ra = $urandom;
      run_frame(ri, ra, k[0], k[2], got);
      check_frame(ri, ra, got, "random");
      repeat ($urandom % 3) @(negedge clk_i);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule